// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block holds the program-counter pair of an in-order pipeline that has one branch delay slot: the address of the instruction being processed now and the address of the one after it. In every clock cycle one instruction is processed. The decode stage presents the class of that instruction (sequential, conditional branch or call) together with its condition field, its annul bit, its displacement field and the current integer flags. On the next edge the block moves the pair forward. The current address always takes the old next address, so the instruction after a branch or call always reaches the pipeline. The next address becomes either the old next address plus four or a computed target.

A conditional branch can flag its delay-slot instruction as annulled. The block asserts `squash` for that instruction while it is at the current address, and it ignores the class and fields that the decode stage presents in that cycle. A call sends the sequence to a PC-relative target and reports its own address as the link value, which the register write-back stage stores in register 15.

Top module: `dslot_pc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` becomes RESET_PC (default 0x1000), `npc` becomes RESET_PC+4, and `squash` and `link_valid` become 0.
- R2: When the effective class is sequential (`ins_cls` = 0, or the reserved value 3), `pc` takes the old `npc` and `npc` takes the old `npc` + 4 on the next edge.
- R3: For a conditional branch (`ins_cls` = 1), the target is `pc` plus the sign-extended `disp[21:0]` times 4, modulo 2^32. On the next edge `pc` takes the old `npc`. `npc` takes the target when the branch is taken and the old `npc` + 4 when it is not.
- R4: The branch is taken by `br_cond` and `flags` (`flags[3]`=N, [2]=Z, [1]=V, [0]=C) as follows. The low three bits select the base: 0 never, 1 Z, 2 Z|(N^V), 3 N^V, 4 C|Z, 5 C, 6 N, 7 V. `br_cond[3]`=1 inverts the base, so 8 is always and 9 to 15 are the negations of 1 to 7.
- R5: After a conditional branch with `annul`=0, `squash` is 0. With `annul`=1 and a branch condition other than 8, `squash` is 1 exactly when the branch was not taken.
- R6: While `squash` is 1, the inputs are ignored and the instruction is treated as sequential: `npc` advances by 4, and `link_valid` stays 0 even when `ins_cls` shows a call.
- R7: A branch with condition 8 and `annul`=1 is taken and still sets `squash` to 1.
- R8: For a call (`ins_cls` = 2), `npc` takes `pc` plus `disp[29:0]` times 4, modulo 2^32, and `pc` takes the old `npc`. `squash` goes to 0.
- R9: After a call, `link_valid` is 1 for exactly one cycle and `link` holds the address of the call instruction. After any other instruction `link_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_cls | input | 2 | Instruction class: 0 sequential, 1 conditional branch, 2 call, 3 treated as sequential |
| br_cond | input | 4 | Branch condition field |
| annul | input | 1 | Annul bit of a conditional branch |
| disp | input | 30 | Displacement in words (a branch uses bits 21:0) |
| flags | input | 4 | Integer flags N, Z, V, C (bit 3 down to bit 0) |
| pc | output | 32 | Address of the instruction being processed |
| npc | output | 32 | Address of the following instruction |
| squash | output | 1 | The instruction at `pc` is annulled |
| link | output | 32 | Return link (address of the last call) |
| link_valid | output | 1 | `link` belongs to the instruction just completed |

## Verification
The pair of addresses is the only state that carries forward, so a wrong `npc` shows up at `pc` one cycle later. A wrong target or condition decode shows at `npc` on the edge right after the branch. A wrong annul flag shows at `squash` right away, and one cycle later it changes whether the next instruction's class has any effect. The bench therefore compares the full pair, the squash flag and the link against its model after every edge, so a fault is found within one or two cycles of the instruction that exposes it.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  typedef enum logic [1:0] {
    CLS_SEQ    = 2'd0,
    CLS_BRANCH = 2'd1,
    CLS_CALL   = 2'd2,
    CLS_RSVD   = 2'd3
  } cls_e;

  localparam logic [3:0] COND_ALWAYS = 4'b1000;
  localparam logic [3:0] COND_NEVER  = 4'b0000;
endpackage

// File: rtl/dslot_cond_eval.sv
module dslot_cond_eval (
  input  logic [3:0] cond,
  input  logic [3:0] flags,
  output logic       taken
);
  logic fn, fz, fv, fc;
  logic base;

  assign fn = flags[3];
  assign fz = flags[2];
  assign fv = flags[1];
  assign fc = flags[0];

  always_comb begin
    case (cond[2:0])
      3'd0:    base = 1'b0;
      3'd1:    base = fz;
      3'd2:    base = fz | (fn ^ fv);
      3'd3:    base = fn ^ fv;
      3'd4:    base = fc | fz;
      3'd5:    base = fc;
      3'd6:    base = fn;
      default: base = fv;
    endcase
  end

  // upper half of the code space is the complement of the lower half
  assign taken = base ^ cond[3];
endmodule

// File: rtl/dslot_target.sv
module dslot_target #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 22
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] target
);
  localparam int WORD_SH = 2;

  logic signed [DISP_W-1:0] sdisp;
  logic [ADDR_W-1:0]        ext;

  assign sdisp  = disp;
  assign ext    = ADDR_W'(sdisp);
  assign target = base + (ext << WORD_SH);
endmodule

// File: rtl/dslot_pc_unit.sv
module dslot_pc_unit
  import dslot_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          BDISP_W  = 22,
  parameter int          CDISP_W  = 30,
  parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         ins_cls,
  input  logic [3:0]         br_cond,
  input  logic               annul,
  input  logic [CDISP_W-1:0] disp,
  input  logic [3:0]         flags,
  output logic [ADDR_W-1:0]  pc,
  output logic [ADDR_W-1:0]  npc,
  output logic               squash,
  output logic [ADDR_W-1:0]  link,
  output logic               link_valid
);
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] PC_INIT = ADDR_W'(RESET_PC);

  cls_e              eff_cls;
  logic              br_taken;
  logic [ADDR_W-1:0] br_target;
  logic [ADDR_W-1:0] call_target;
  logic [ADDR_W-1:0] seq_next;
  logic [ADDR_W-1:0] npc_d;
  logic              squash_d;

  // an annulled instruction has no effect of its own
  assign eff_cls  = squash ? CLS_SEQ : cls_e'(ins_cls);
  assign seq_next = npc + STEP;

  dslot_cond_eval u_cond (
    .cond  (br_cond),
    .flags (flags),
    .taken (br_taken)
  );

  dslot_target #(.ADDR_W(ADDR_W), .DISP_W(BDISP_W)) u_br_tgt (
    .base   (pc),
    .disp   (disp[BDISP_W-1:0]),
    .target (br_target)
  );

  dslot_target #(.ADDR_W(ADDR_W), .DISP_W(CDISP_W)) u_call_tgt (
    .base   (pc),
    .disp   (disp),
    .target (call_target)
  );

  always_comb begin
    npc_d    = seq_next;
    squash_d = 1'b0;
    case (eff_cls)
      CLS_BRANCH: begin
        if (br_taken) npc_d = br_target;
        squash_d = annul & (~br_taken | (br_cond == COND_ALWAYS));
      end
      CLS_CALL: npc_d = call_target;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= PC_INIT;
      npc        <= PC_INIT + STEP;
      squash     <= 1'b0;
      link       <= '0;
      link_valid <= 1'b0;
    end else begin
      pc         <= npc;
      npc        <= npc_d;
      squash     <= squash_d;
      link_valid <= (eff_cls == CLS_CALL);
      if (eff_cls == CLS_CALL) link <= pc;
    end
  end

  // R4: extremes of the condition table
  p_always_taken_r4: assert property (@(posedge clk) disable iff (rst)
    (br_cond == COND_ALWAYS) |-> br_taken);
  p_never_taken_r4: assert property (@(posedge clk) disable iff (rst)
    (br_cond == COND_NEVER) |-> !br_taken);

  // R3: addresses stay word aligned from an aligned reset value
  p_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    (PC_INIT[1:0] == 2'b00) |-> (pc[1:0] == 2'b00 && npc[1:0] == 2'b00));

  // R5: a non-annulling branch never squashes its delay slot
  p_no_annul_r5: assert property (@(posedge clk) disable iff (rst)
    (eff_cls == CLS_BRANCH && !annul) |=> !squash);

  // R6: a squashed slot advances sequentially and makes no link
  p_squash_seq_r6: assert property (@(posedge clk) disable iff (rst)
    squash |=> (npc == $past(npc) + STEP) && !link_valid);

  // R8: a call never annuls the following instruction
  p_call_no_squash_r8: assert property (@(posedge clk) disable iff (rst)
    link_valid |-> !squash);
endmodule

// File: tb/test_dslot_pc_unit.sv
module test_dslot_pc_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  ins_cls;
  logic [3:0]  br_cond;
  logic        annul;
  logic [29:0] disp;
  logic [3:0]  flags;
  logic [31:0] pc, npc, link;
  logic        squash, link_valid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] m_pc, m_npc, m_link;
  logic        m_sq, m_lv;

  always #(CLK_PERIOD/2) clk = ~clk;

  dslot_pc_unit i_dslot_pc_unit (
    .clk(clk), .rst(rst), .ins_cls(ins_cls), .br_cond(br_cond),
    .annul(annul), .disp(disp), .flags(flags), .pc(pc), .npc(npc),
    .squash(squash), .link(link), .link_valid(link_valid)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog (R2): actual cycles=%0d expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic bit ref_taken(input logic [3:0] c, input logic [3:0] f);
    bit n, z, v, cy;
    n = f[3]; z = f[2]; v = f[1]; cy = f[0];
    case (c)
      4'd0:  return 0;
      4'd1:  return z;
      4'd2:  return z || (n != v);
      4'd3:  return n != v;
      4'd4:  return cy || z;
      4'd5:  return cy;
      4'd6:  return n;
      4'd7:  return v;
      4'd8:  return 1;
      4'd9:  return !z;
      4'd10: return !(z || (n != v));
      4'd11: return n == v;
      4'd12: return !(cy || z);
      4'd13: return !cy;
      4'd14: return !n;
      default: return !v;
    endcase
  endfunction

  task automatic compare(input string tag);
    bit bad;
    checks++;
    bad = (pc !== m_pc) || (npc !== m_npc) || (squash !== m_sq) ||
          (link_valid !== m_lv) || (m_lv && link !== m_link);
    if (bad) begin
      errors++;
      $display("FAIL %s: actual pc=%h npc=%h sq=%b lv=%b link=%h expected pc=%h npc=%h sq=%b lv=%b link=%h",
               tag, pc, npc, squash, link_valid, link, m_pc, m_npc, m_sq, m_lv, m_link);
    end
  endtask

  task automatic step(input int cls, input logic [3:0] c, input bit an,
                      input logic [29:0] d, input logic [3:0] f, input string tag);
    int eff;
    logic [31:0] nn;
    logic [31:0] off;
    bit tk, nq;
    ins_cls = 2'(cls); br_cond = c; annul = an; disp = d; flags = f;
    @(posedge clk);
    eff = m_sq ? 0 : cls;
    nq = 0; m_lv = 0;
    nn = m_npc + 32'd4;
    if (eff == 1) begin
      tk = ref_taken(c, f);
      off = {{8{d[21]}}, d[21:0], 2'b00};
      if (tk) nn = m_pc + off;
      nq = an && (!tk || c == 4'd8);
    end else if (eff == 2) begin
      nn = m_pc + {d, 2'b00};
      m_link = m_pc;
      m_lv = 1;
    end
    m_pc = m_npc; m_npc = nn; m_sq = nq;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    rst = 1; ins_cls = 0; br_cond = 0; annul = 0; disp = 0; flags = 0;
    m_link = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_pc = RST_PC; m_npc = RST_PC + 4; m_sq = 0; m_lv = 0;
    compare("R1");

    step(0, 0, 0, 0, 0, "R2");
    step(3, 0, 0, 30'h3FF, 0, "R2");
    step(1, 4'd1, 0, 30'h10, 4'b0100, "R3");
    step(0, 0, 0, 0, 0, "R5");
    step(1, 4'd1, 1, 30'h10, 4'b0000, "R5");
    step(2, 0, 0, 30'h100, 0, "R6");
    step(1, 4'd9, 1, 30'h3FFFF0, 4'b0000, "R5");
    step(0, 0, 0, 0, 0, "R5");
    step(1, 4'd8, 1, 30'h20, 0, "R7");
    step(1, 4'd8, 0, 30'h20, 0, "R7");
    step(1, 4'd0, 0, 30'h40, 4'b1111, "R4");
    step(2, 0, 0, 30'h3FFF_FF00, 0, "R8");
    step(0, 0, 0, 0, 0, "R9");
    step(2, 0, 0, 30'h0000_0100, 0, "R9");
    step(1, 4'd8, 0, 30'h200000, 0, "R3");
    step(2, 0, 0, 30'h1234, 0, "R8");
    step(0, 0, 0, 0, 0, "R9");
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        step(1, 4'(c), bit'((c ^ f) & 1), 30'(f * 3 + 1), 4'(f), "R4");
      end
    end
    step(0, 0, 0, 0, 0, "R2");
    step(1, 4'd8, 0, 30'h8, 0, "R8");
    step(2, 0, 0, 30'h3000_0000, 0, "R8");
    step(1, 4'd5, 1, 30'h4, 4'b0000, "R6");
    step(3, 0, 0, 0, 0, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule